// File: doc/BRIEF.md
# Test Access Port Instruction and Data-Register Unit

This block is the back end of a serial test access port. A standard sixteen-state controller, stepped by the test clock and the mode-select input, produces capture, shift and update strobes for two paths: a 4-bit instruction path and a data path. The instruction currently in effect picks one of four data registers to place between the serial input and the serial output. The four are a 32-bit identification register, a boundary-scan chain of parameterised length, a one-bit device-reset register and a one-bit bypass register.

The serial output is retimed onto the falling edge of the test clock. An enable output marks when that output carries shifted data. The boundary-scan chain samples a pin vector during capture. At update it copies its contents into a set of holding latches, and those latches are brought out but never drive the pins. The device-reset register drives a reset-request output directly, with no update stage in between. That register is separate from the controller and the instruction register, so loading it does not disturb either one.

Top module: `jtag_dr_unit`

## Requirements
- R1: Opcode decode on the 4-bit instruction: 4'h1 selects the identification register, 4'h2 selects the boundary-scan chain (sample/preload), 4'hC selects the device-reset register, and 4'hF and every other value select the bypass register.
- R2: Synchronous reset (`rst` high at a rising `tck` edge), and the controller's Test-Logic-Reset state, both set the instruction to 4'h1.
- R3: In Capture-IR the instruction shift register loads 4'b0001, which then shifts out LSB first. The shifted value becomes the instruction only at Update-IR, and the instruction is stable in every other state.
- R4: Under 4'h1, Capture-DR loads {ID_VERSION[31:28], ID_PART[27:12], ID_MANUF[11:1], 1'b1}, and Shift-DR moves it out LSB first, with `tdi` entering at bit 31.
- R5: Under 4'h2, Capture-DR loads `pins_in`, and Shift-DR shifts the chain LSB first, with `tdi` entering at the top bit. Update-DR copies the chain into `bsr_latch`. Under any other instruction `bsr_latch` does not change.
- R6: Under 4'hC, each Shift-DR edge loads `tdi` into the one-bit reset register. There is no capture. `dev_reset_req` follows the register's content at once, with no update stage. The register changes under no other instruction and is cleared only by `rst`. It affects neither the controller nor the instruction.
- R7: Under bypass, Capture-DR loads 0. Shift-DR then delays `tdi` by one stage, so the first bit out is 0.
- R8: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is then the LSB of the selected register.
- R9: The controller follows the standard state graph on `tms`, and five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Controller mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pins_in | input | BSR_LEN | Pin values sampled by the boundary-scan chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | High while tdo carries shifted data |
| dev_reset_req | output | 1 | Device reset request from the reset register |
| bsr_latch | output | BSR_LEN | Boundary-scan update latches |

## Verification
The shift registers and the reset register change on the rising edge that leaves the Capture, Shift or Update state, and `dev_reset_req` and `bsr_latch` can be read one time unit after that edge. `tdo` changes half a period later, on the falling edge. The bench therefore reads every serial bit one time unit after a falling edge, before it drives the next `tms`/`tdi` pair. To check that `tdo` has not moved, it also samples just after each shifting rising edge. All sixteen opcodes are swept, each with a 40-bit data scan. Every result is compared against a value worked out arithmetically from the requirement, at the cycle counted above.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_IDCODE   = 4'h1;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 4'h2;
    localparam logic [IR_W-1:0] OP_DEVRST   = 4'hC;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PA_DR   = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PA_IR   = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_ID,
        PATH_BSR,
        PATH_RST,
        PATH_BYP
    } dr_path_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } strobe_t;

    function automatic dr_path_e decode_op(input logic [IR_W-1:0] op);
        dr_path_e p;
        case (op)
            OP_IDCODE: p = PATH_ID;
            OP_SAMPLE: p = PATH_BSR;
            OP_DEVRST: p = PATH_RST;
            default:   p = PATH_BYP;
        endcase
        return p;
    endfunction

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_dr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output strobe_t    ir_stb,
    output strobe_t    dr_stb,
    output logic       in_reset
);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    always_comb begin
        ir_stb.capture = (state == ST_CAP_IR);
        ir_stb.shift   = (state == ST_SH_IR);
        ir_stb.update  = (state == ST_UPD_IR);
        dr_stb.capture = (state == ST_CAP_DR);
        dr_stb.shift   = (state == ST_SH_DR);
        dr_stb.update  = (state == ST_UPD_DR);
        in_reset       = (state == ST_RESET);
    end

endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
    import jtag_dr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tdi,
    input  strobe_t         stb,
    input  logic            in_reset,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            if (stb.capture)    ir_sr <= IR_CAPTURE;
            else if (stb.shift) ir_sr <= {tdi, ir_sr[IR_W-1:1]};

            if (in_reset)        ir_q <= OP_IDCODE;
            else if (stb.update) ir_q <= ir_sr;
        end
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
    import jtag_dr_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter logic [31:0] ID_VALUE = 32'h1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tdi,
    input  strobe_t            stb,
    input  dr_path_e           path,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] latch_q,
    output logic               rst_bit
);

    localparam int ID_W = 32;

    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic               byp_q;

    wire sel_id  = (path == PATH_ID);
    wire sel_bsr = (path == PATH_BSR);
    wire sel_rst = (path == PATH_RST);
    wire sel_byp = (path == PATH_BYP);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_sr <= '0;
        end else if (sel_id && stb.capture) begin
            id_sr <= ID_VALUE;
        end else if (sel_id && stb.shift) begin
            id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
    end

    // boundary chain cells, one per pin
    for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
        logic shift_in;
        if (k == BSR_LEN - 1) begin : g_top
            assign shift_in = tdi;
        end else begin : g_mid
            assign shift_in = bsr_sr[k+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                bsr_sr[k]  <= 1'b0;
                latch_q[k] <= 1'b0;
            end else if (sel_bsr) begin
                if (stb.capture)     bsr_sr[k] <= pins[k];
                else if (stb.shift)  bsr_sr[k] <= shift_in;
                if (stb.update)      latch_q[k] <= bsr_sr[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         rst_bit <= 1'b0;
        else if (sel_rst && stb.shift)   rst_bit <= tdi;
    end

    always_ff @(posedge clk) begin
        if (rst)                         byp_q <= 1'b0;
        else if (sel_byp && stb.capture) byp_q <= 1'b0;
        else if (sel_byp && stb.shift)   byp_q <= tdi;
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_lsb = id_sr[0];
            PATH_BSR: dr_lsb = bsr_sr[0];
            PATH_RST: dr_lsb = rst_bit;
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_dr_unit.sv
module jtag_dr_unit
    import jtag_dr_pkg::*;
#(
    parameter int          BSR_LEN    = 8,
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'h5A3C,
    parameter logic [10:0] ID_MANUF   = 11'h0A5
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               dev_reset_req,
    output logic [BSR_LEN-1:0] bsr_latch
);

    localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};

    tap_state_e      state;
    strobe_t         ir_stb;
    strobe_t         dr_stb;
    logic            in_reset;
    logic [IR_W-1:0] ir_cur;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_path_e        path;
    logic            tdo_d;
    logic            tdo_en_d;

    jtag_tap_fsm u_fsm (
        .clk      (tck),
        .rst      (rst),
        .tms      (tms),
        .state    (state),
        .ir_stb   (ir_stb),
        .dr_stb   (dr_stb),
        .in_reset (in_reset)
    );

    jtag_ir u_ir (
        .clk      (tck),
        .rst      (rst),
        .tdi      (tdi),
        .stb      (ir_stb),
        .in_reset (in_reset),
        .ir_q     (ir_cur),
        .ir_lsb   (ir_lsb)
    );

    assign path = decode_op(ir_cur);

    jtag_dr_bank #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .clk     (tck),
        .rst     (rst),
        .tdi     (tdi),
        .stb     (dr_stb),
        .path    (path),
        .pins    (pins_in),
        .dr_lsb  (dr_lsb),
        .latch_q (bsr_latch),
        .rst_bit (dev_reset_req)
    );

    always_comb begin
        tdo_en_d = ir_stb.shift | dr_stb.shift;
        tdo_d    = ir_stb.shift ? ir_lsb : dr_lsb;
    end

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_en_d ? tdo_d : 1'b0;
            tdo_en <= tdo_en_d;
        end
    end

endmodule

// File: rtl/jtag_dr_unit_chk.sv
module jtag_dr_unit_chk
    import jtag_dr_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               tms,
    input logic [3:0]         state,
    input logic [IR_W-1:0]    ir,
    input logic               tdo_en,
    input logic               dev_reset_req,
    input logic [BSR_LEN-1:0] bsr_latch
);

    logic [2:0] ones_run;

    always_ff @(posedge clk) begin
        if (rst)               ones_run <= 3'd0;
        else if (!tms)         ones_run <= 3'd0;
        else if (ones_run < 5) ones_run <= ones_run + 3'd1;
    end

    // R2: Test-Logic-Reset forces the identification opcode
    assert_tlr_idcode_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET) |=> (ir == OP_IDCODE));

    // R3: instruction only moves at Update-IR or Test-Logic-Reset
    assert_ir_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir));

    // R5: update latches hold except at Update-DR under sample/preload
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_UPD_DR && ir == OP_SAMPLE) |=> $stable(bsr_latch));

    // R6: reset request only moves while shifting under the reset opcode
    assert_rst_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_SH_DR && ir == OP_DEVRST) |=> $stable(dev_reset_req));

    // R8: output enable matches the shift states
    assert_tdo_en_R8: assert property (@(posedge clk) disable iff (rst)
        tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

    // R9: five high tms edges reach Test-Logic-Reset
    assert_five_ones_R9: assert property (@(posedge clk) disable iff (rst)
        (ones_run == 3'd5) |-> (state == ST_RESET));

endmodule

bind jtag_dr_unit jtag_dr_unit_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .clk           (tck),
    .rst           (rst),
    .tms           (tms),
    .state         (state),
    .ir            (ir_cur),
    .tdo_en        (tdo_en),
    .dev_reset_req (dev_reset_req),
    .bsr_latch     (bsr_latch)
);

// File: tb/jtag_dr_unit_test.sv
module jtag_dr_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int BLEN = 8;
    localparam int NBITS = 40;
    localparam logic [31:0] EXP_ID = {4'h3, 16'h5A3C, 11'h0A5, 1'b1};

    logic            tck = 1'b0;
    logic            rst = 1'b1;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic [BLEN-1:0] pins_in = '0;
    logic            tdo, tdo_en, dev_reset_req;
    logic [BLEN-1:0] bsr_latch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    jtag_dr_unit #(.BSR_LEN(BLEN)) uut (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pins_in(pins_in),
        .tdo(tdo), .tdo_en(tdo_en), .dev_reset_req(dev_reset_req),
        .bsr_latch(bsr_latch)
    );

    initial forever #(CLK_PERIOD/2) tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [3:0] got);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        check(tdo_en === 1'b1, "R8 enable in Shift-IR", 64'(tdo_en), 64'd1);
        for (int i = 0; i < 4; i++) begin
            got[i] = tdo;
            step(i == 3, op[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input logic [63:0] din, output logic [63:0] got);
        bit held;
        held = 1;
        got = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < NBITS; i++) begin
            got[i] = tdo;
            tms = (i == NBITS-1);
            tdi = din[i];
            @(posedge tck);
            #1;
            if (tdo !== got[i]) held = 0;
            @(negedge tck);
            #1;
        end
        check(held, "R8 tdo steady after rising edge", 64'(held), 64'd1);
        check(tdo_en === 1'b0, "R8 enable low in Exit1-DR", 64'(tdo_en), 64'd0);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0]      irout;
        logic [63:0]     dout, din, exp;
        logic [63:0]     mask;
        logic            rst_model;
        logic [BLEN-1:0] latch_model;
        mask = (64'd1 << NBITS) - 64'd1;
        rst_model = 0;
        latch_model = '0;

        @(negedge tck); #1;
        step(1, 0); step(1, 0);
        check(tdo_en === 0, "R8 enable low in reset", 64'(tdo_en), 64'd0);
        check(dev_reset_req === 0, "R6 reset request cleared", 64'(dev_reset_req), 64'd0);
        check(bsr_latch === '0, "R5 latches cleared", 64'(bsr_latch), 64'd0);
        rst = 0;
        step(0, 0);

        // R2: power-up instruction is identification
        din = 64'h00000000_A5C3F00F;
        scan_dr(din, dout);
        exp = (64'(EXP_ID) | (din << 32)) & mask;
        check(dout == exp, "R2 R4 identification after reset", dout, exp);

        // R1 sweep over all sixteen opcodes
        for (int op = 0; op < 16; op++) begin
            pins_in = BLEN'(op * 37 + 5);
            scan_ir(4'(op), irout);
            check(irout == 4'b0001, "R3 capture-IR value", 64'(irout), 64'd1);
            din = 64'h9E3779B97F4A7C15 * 64'(op + 1);
            scan_dr(din, dout);
            case (op)
                1:  exp = 64'(EXP_ID) | (din << 32);
                2:  exp = 64'(pins_in) | (din << BLEN);
                12: exp = 64'(rst_model) | (din << 1);
                default: exp = din << 1;
            endcase
            exp &= mask;
            if (op == 1)       check(dout == exp, "R4 identification shift", dout, exp);
            else if (op == 2)  check(dout == exp, "R5 boundary capture and shift", dout, exp);
            else if (op == 12) check(dout == exp, "R6 reset register shift", dout, exp);
            else               check(dout == exp, "R1 R7 bypass for other opcodes", dout, exp);
            if (op == 2)  latch_model = din[NBITS-1 -: BLEN];
            if (op == 12) rst_model = din[NBITS-1];
            check(bsr_latch == latch_model, "R5 update latches", 64'(bsr_latch), 64'(latch_model));
            check(dev_reset_req == rst_model, "R6 reset request level", 64'(dev_reset_req), 64'(rst_model));
        end

        // R6: asserting reset request leaves instruction and controller intact
        scan_ir(4'hC, irout);
        din = 64'hFFFFFFFFFFFFFFFF;
        scan_dr(din, dout);
        check(dev_reset_req === 1, "R6 reset request set", 64'(dev_reset_req), 64'd1);
        din = 64'h0;
        scan_dr(din, dout);
        check(dout == (64'd1 & mask), "R6 instruction kept after reset request", dout, 64'd1);
        check(dev_reset_req === 0, "R6 reset request released", 64'(dev_reset_req), 64'd0);

        // R9 R2: five tms-high clocks from mid-IR return to identification
        scan_ir(4'hF, irout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        check(tdo_en === 0, "R9 left shift after five ones", 64'(tdo_en), 64'd0);
        step(0, 0);
        din = 64'h12345678_9ABCDEF0;
        scan_dr(din, dout);
        exp = (64'(EXP_ID) | (din << 32)) & mask;
        check(dout == exp, "R9 R2 identification after Test-Logic-Reset", dout, exp);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule